// File: doc/BRIEF.md
# Bloom-Filter Address Signature Register

This block keeps a conservative record of a set of cache-line addresses for one hardware thread, so that transactional software can use it as a read-set or write-set signature. Each recorded address sets four bits in a register of `SIG_BITS` bits. Each bit is picked by its own fixed hash of the line address. A membership query answers "hit" only when all four of its bits are set. The answer may be a false positive but never a false negative.

Software drives a single command port. Its operations clear the whole register, record an address, query an address, read out one word-sized slice, or overwrite one word-sized slice. Query and read-out results come back registered, one cycle after the command. A second, purely combinational query port checks addresses from incoming coherence requests in the same cycle. It runs alongside the command port and never stalls it.

Top module: `sig_filter_reg`

## Requirements
- R1: While `rst_n` is low and after its release, every signature bit is 0: every slice reads out as 0 and every query misses.
- R2: The low `LINE_OFS` (default 5) address bits are dropped before hashing, so addresses that differ only in those bits give identical results.
- R3: Let L be `addr >> LINE_OFS` and P be L with its `ADDR_W-LINE_OFS` bits reversed in order. Recording an address (op 2) sets bits L, P, P>>10 and {L[7:0],L[15:8]}, each taken modulo `SIG_BITS`, and sets no other bit.
- R4: A query (op 3) raises `rsp_valid` and gives `rsp_hit`=1 on the next cycle exactly when all four bits of R3 are set.
- R5: Every recorded address keeps hitting until the next clear, restore or reset.
- R6: Clear (op 1) zeroes every bit in one cycle.
- R7: Read-out (op 4) raises `rsp_valid` on the next cycle with `rsp_data` equal to bits `[k*WORD_W +: WORD_W]`, where k is `cmd_slice`.
- R8: Restore (op 5) writes `cmd_wdata` into slice k and leaves every other slice unchanged.
- R9: `snp_hit` depends only on `snp_addr` and the current register, in the same cycle, with no clock delay. A record issued in the same cycle is not yet seen.
- R10: Op 0, ops 6 and 7, and any op with `cmd_valid` low change no bit and raise no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (0 idle, 1 clear, 2 record, 3 query, 4 read-out, 5 restore) |
| cmd_addr | input | ADDR_W | Byte address for record or query |
| cmd_slice | input | SL_W | Slice number for read-out or restore |
| cmd_wdata | input | WORD_W | Restore data |
| snp_addr | input | ADDR_W | Coherence-request address to look up |
| snp_hit | output | 1 | Combinational lookup result for `snp_addr` |
| rsp_valid | output | 1 | Query or read-out result present |
| rsp_hit | output | 1 | Query result |
| rsp_data | output | WORD_W | Read-out slice |

## Verification
Results on the command port are due exactly one rising edge after the command is accepted. The bench drives each command at a falling edge and then compares `rsp_valid`, `rsp_hit` and `rsp_data` at the next falling edge against a behavioural model. That model was advanced at the rising edge in between. `snp_hit` is due in the same cycle, so it is compared 1 ns after the address is driven. The comparison uses the model state from before that cycle's rising edge, which is how a record issued in the same cycle is shown to be invisible. Register changes made by clear, record and restore become observable from the following cycle on, through queries and read-outs.

// File: rtl/sig_filter_reg.sv
module sig_filter_reg #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 5,
  parameter int SIG_BITS = 1024,
  parameter int WORD_W   = 32,
  parameter int SHIFT2   = 10,
  localparam int IDX_W   = $clog2(SIG_BITS),
  localparam int LINE_W  = ADDR_W - LINE_OFS,
  localparam int NSLICE  = SIG_BITS / WORD_W,
  localparam int SL_W    = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SL_W-1:0]   cmd_slice,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_data
);

  localparam logic [2:0] OP_CLEAR   = 3'd1;
  localparam logic [2:0] OP_INSERT  = 3'd2;
  localparam logic [2:0] OP_TEST    = 3'd3;
  localparam logic [2:0] OP_SAVE    = 3'd4;
  localparam logic [2:0] OP_RESTORE = 3'd5;

  function automatic logic [SIG_BITS-1:0] sel_mask(input logic [ADDR_W-1:0] a);
    logic [LINE_W-1:0] ln, pm;
    logic [31:0] h [4];
    ln = a[ADDR_W-1:LINE_OFS];
    for (int i = 0; i < LINE_W; i++) pm[i] = ln[LINE_W-1-i];
    h[0] = 32'(ln);
    h[1] = 32'(pm);
    h[2] = 32'(pm >> SHIFT2);
    h[3] = {16'd0, ln[7:0], ln[15:8]};
    sel_mask = '0;
    for (int k = 0; k < 4; k++) sel_mask[h[k][IDX_W-1:0]] = 1'b1;
  endfunction

  logic [SIG_BITS-1:0] sig;
  logic [SIG_BITS-1:0] cmd_mask, snp_mask, slice_fmask;
  logic [WORD_W-1:0]   slice_rd;
  logic                do_clear, do_insert, do_test, do_save, do_restore;
  logic                unused_low;

  assign unused_low  = ^{cmd_addr[LINE_OFS-1:0], snp_addr[LINE_OFS-1:0]};
  assign cmd_mask    = sel_mask(cmd_addr);
  assign snp_mask    = sel_mask(snp_addr);
  assign snp_hit     = (sig & snp_mask) == snp_mask;
  assign slice_rd    = sig[int'(cmd_slice)*WORD_W +: WORD_W];
  assign slice_fmask = {{(SIG_BITS-WORD_W){1'b0}}, {WORD_W{1'b1}}} << (int'(cmd_slice)*WORD_W);

  assign do_clear   = cmd_valid && cmd_op == OP_CLEAR;
  assign do_insert  = cmd_valid && cmd_op == OP_INSERT;
  assign do_test    = cmd_valid && cmd_op == OP_TEST;
  assign do_save    = cmd_valid && cmd_op == OP_SAVE;
  assign do_restore = cmd_valid && cmd_op == OP_RESTORE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= '0;
    end else if (do_clear) begin
      sig <= '0;
    end else if (do_insert) begin
      sig <= sig | cmd_mask;
    end else if (do_restore) begin
      sig[int'(cmd_slice)*WORD_W +: WORD_W] <= cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= do_test || do_save;
      rsp_hit   <= do_test && ((sig & cmd_mask) == cmd_mask);
      rsp_data  <= do_save ? slice_rd : '0;
    end
  end

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_clear) |-> sig == '0); // R6

  AST_INSERT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_insert) |-> (sig & $past(cmd_mask)) == $past(cmd_mask)); // R3

  AST_NO_FALSE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(do_clear || do_restore) |-> (sig & $past(sig)) == $past(sig)); // R5

  AST_RESTORE_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_restore) |-> ((sig ^ $past(sig)) & ~$past(slice_fmask)) == '0); // R8

  AST_SAVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_save) |-> rsp_valid && rsp_data == $past(slice_rd)); // R7

  AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid) && ($past(cmd_op) == OP_TEST || $past(cmd_op) == OP_SAVE)); // R10

endmodule

// File: tb/sig_filter_reg_tb.sv
module sig_filter_reg_tb_top;
  localparam int SIG  = 1024;
  localparam int WW   = 32;
  localparam int NSL  = SIG / WW;
  localparam int SLW  = $clog2(NSL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [31:0] cmd_addr = '0;
  logic [SLW-1:0] cmd_slice = '0;
  logic [WW-1:0] cmd_wdata = '0;
  logic [31:0] snp_addr = '0;
  logic snp_hit, rsp_valid, rsp_hit;
  logic [WW-1:0] rsp_data;

  always #5 clk = ~clk;

  sig_filter_reg #(.SIG_BITS(SIG), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_slice(cmd_slice), .cmd_wdata(cmd_wdata),
    .snp_addr(snp_addr), .snp_hit(snp_hit), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data));

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit ref_sig [SIG];
  bit exp_valid = 0, exp_hit = 0;
  logic [WW-1:0] exp_data = '0;
  bit done = 0;

  function automatic int unsigned ref_idx(input logic [31:0] a, input int k);
    logic [31:0] ln, pm, v;
    ln = a >> 5;
    pm = '0;
    for (int i = 0; i < 27; i++) if (ln[i]) pm[26-i] = 1'b1;
    case (k)
      0: v = ln;
      1: v = pm;
      2: v = pm >> 10;
      default: v = ((ln & 32'hff) << 8) | ((ln >> 8) & 32'hff);
    endcase
    return v % SIG;
  endfunction

  function automatic bit ref_member(input logic [31:0] a);
    bit r = 1;
    for (int k = 0; k < 4; k++) if (!ref_sig[ref_idx(a, k)]) r = 0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string t, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SIG; i++) ref_sig[i] = 0;
      exp_valid = 0; exp_hit = 0; exp_data = '0;
    end else begin
      exp_valid = cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4);
      exp_hit   = cmd_valid && cmd_op == 3'd3 && ref_member(cmd_addr);
      exp_data  = '0;
      if (cmd_valid && cmd_op == 3'd4)
        for (int b = 0; b < WW; b++) exp_data[b] = ref_sig[int'(cmd_slice)*WW + b];
      if (cmd_valid) begin
        case (cmd_op)
          3'd1: for (int i = 0; i < SIG; i++) ref_sig[i] = 0;
          3'd2: for (int k = 0; k < 4; k++) ref_sig[ref_idx(cmd_addr, k)] = 1;
          3'd5: for (int b = 0; b < WW; b++) ref_sig[int'(cmd_slice)*WW + b] = cmd_wdata[b];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rsp_valid == exp_valid, tag, "rsp_valid", rsp_valid, exp_valid);
      if (exp_valid) begin
        chk(rsp_hit == exp_hit, tag, "rsp_hit", rsp_hit, exp_hit);
        chk(rsp_data == exp_data, tag, "rsp_data", rsp_data, exp_data);
      end
    end
  end

  task automatic do_cmd(input bit v, input logic [2:0] op, input logic [31:0] a,
                        input int sl, input logic [31:0] wd, input logic [31:0] sa);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a;
    cmd_slice = SLW'(sl); cmd_wdata = wd; snp_addr = sa;
    #1;
    chk(snp_hit == ref_member(sa), "R9", "snp_hit", snp_hit, ref_member(sa));
  endtask

  task automatic idle();
    do_cmd(0, 3'd0, 32'h0, 0, 32'h0, 32'h0);
  endtask

  logic [31:0] lfsr = 32'hACE1_2345;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  logic [31:0] addrs [40];

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid == 0 && snp_hit == 0, "R1", "reset outputs", {rsp_valid, snp_hit}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    for (int s = 0; s < NSL; s++) do_cmd(1, 3'd4, 32'h0, s, 32'h0, 32'h1000_0000 + s * 64);
    do_cmd(1, 3'd3, 32'hDEAD_BEE0, 0, 0, 32'h1234_5678);
    idle();
    chk(rsp_hit == 0, "R1", "query after reset", rsp_hit, 0);

    tag = "R2";
    do_cmd(1, 3'd2, 32'h1234_5660, 0, 0, 32'h0);
    do_cmd(1, 3'd3, 32'h1234_567F, 0, 0, 32'h1234_5661);
    idle();
    chk(rsp_hit == 1, "R2", "offset-only difference hits", rsp_hit, 1);
    do_cmd(1, 3'd3, 32'h1234_5640, 0, 0, 32'h0);
    idle();

    tag = "R5";
    for (int i = 0; i < 40; i++) begin
      lfsr = nxt(lfsr); addrs[i] = lfsr;
      do_cmd(1, 3'd2, addrs[i], 0, 0, lfsr ^ 32'h5555_0000);
    end
    for (int i = 0; i < 40; i++) do_cmd(1, 3'd3, addrs[i] | 32'h1F, 0, 0, addrs[i]);
    idle();
    chk(rsp_hit == 1, "R5", "last recorded address", rsp_hit, 1);

    tag = "R4";
    for (int i = 0; i < 60; i++) begin
      lfsr = nxt(lfsr);
      do_cmd(1, 3'd3, lfsr, 0, 0, nxt(lfsr));
    end

    tag = "R3";
    for (int s = 0; s < NSL; s++) do_cmd(1, 3'd4, 32'h0, s, 32'h0, 32'h0);
    idle();

    tag = "R9";
    do_cmd(1, 3'd2, 32'h0BAD_F00D, 0, 0, 32'h0BAD_F00D);
    do_cmd(0, 3'd0, 32'h0, 0, 0, 32'h0BAD_F000);
    chk(snp_hit == 1, "R9", "snoop after record", snp_hit, 1);

    tag = "R8";
    do_cmd(1, 3'd5, 32'h0, 3, 32'hA5A5_F00F, 32'h0);
    do_cmd(1, 3'd4, 32'h0, 3, 32'h0, 32'h0);
    do_cmd(1, 3'd4, 32'h0, 4, 32'h0, 32'h0);
    chk(rsp_data == 32'hA5A5_F00F, "R8", "restored slice", rsp_data, 32'hA5A5_F00F);
    for (int s = 0; s < NSL; s++) do_cmd(1, 3'd4, 32'h0, s, 32'h0, 32'h0);

    tag = "R10";
    do_cmd(1, 3'd6, 32'h7777_7777, 5, 32'hFFFF_FFFF, 32'h0);
    do_cmd(1, 3'd7, 32'h6666_6660, 6, 32'hFFFF_FFFF, 32'h0);
    do_cmd(0, 3'd2, 32'h5151_5150, 0, 32'h0, 32'h0);
    do_cmd(0, 3'd5, 32'h0, 7, 32'hFFFF_FFFF, 32'h0);
    do_cmd(1, 3'd0, 32'h4242_4240, 0, 32'h0, 32'h0);
    for (int s = 0; s < NSL; s++) do_cmd(1, 3'd4, 32'h0, s, 32'h0, 32'h0);
    do_cmd(1, 3'd3, 32'h5151_5150, 0, 0, 32'h5151_5150);

    tag = "R6";
    do_cmd(1, 3'd1, 32'h0, 0, 0, 32'h0);
    do_cmd(1, 3'd3, addrs[0], 0, 0, addrs[1]);
    idle();
    chk(rsp_hit == 0, "R6", "query after clear", rsp_hit, 0);
    for (int s = 0; s < NSL; s++) do_cmd(1, 3'd4, 32'h0, s, 32'h0, addrs[s % 40]);
    idle();
    idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule